// File: doc/BRIEF.md
# Upstream Serial Frame Assembler

This block forms the 256-bit frame that a codec sends back to its controller and shifts it out on a single serial data line, one bit per bit-clock edge. The frame opens with a 16-bit tag word and continues with twelve 20-bit slots. The tag word holds the codec-ready flag and one valid flag for each slot. Slot 1 echoes the index of a register read and carries the per-slot sample-request flags. Slot 2 returns the read data. Slots 3 to 11 carry 18-bit capture samples. Slot 12 carries a general-purpose status word.

A separate sync detector pulses `frame_start` for one cycle. On that edge the assembler takes one snapshot of all its inputs. On that edge and on each of the 255 edges after it, it drives the next frame bit, most significant bit first. When the frame ends the line returns to zero until the next pulse. Register decoding, sample-rate conversion and the capture path stay outside this block. It only formats what it is given.

Frame position p counts from 0, which is the first bit sent. Tag bit t sits at position 15 − t. Bit b of slot s (1..12) sits at position 16 + 20·(s − 1) + (19 − b).

Top module: `upstream_frame_tx`

## Requirements
- R1: The clock edge that samples `frame_start` high puts frame position 0 on `sdata`. Each later edge advances one position, up to position 255. A `frame_start` pulse in the middle of a frame drops the rest of that frame and begins a new one from position 0.
- R2: Tag bits are as follows. Bit 15 is codec ready. Bits 14 and 13 are both set when a read response is pending. Bit 15 − k is the valid flag of capture slot k (3..11). Bit 3 is the slot-12 valid flag. Bits 2:0 are zero.
- R3: If `codec_ready` is low at the start edge, all 256 bits of that frame are zero.
- R4: In slot 1, bit 19 is zero. Bits 18:12 hold the read index while a read is pending and are zero otherwise. Bit 14 − k holds the sample-request flag of slot k (3..11). Bits 2:0 are zero.
- R5: When `vra_en` is low, every sample-request flag in slot 1 is sent as zero.
- R6: While a read is pending, slot 2 holds the 16-bit read data in bits 19:4 and zero in bits 3:0. With no read pending, slot 2 is all zero.
- R7: A valid capture slot holds its 18-bit sample in bits 19:2 and zero in bits 1:0. A capture slot whose valid flag is clear is all zero.
- R8: Slot 12 holds the 20-bit status word when `gp_valid` is set and is all zero otherwise.
- R9: Inputs are sampled only on the start edge. Changes to them during a frame leave the bits of that frame unchanged.
- R10: `sdata` is zero while in reset, after reset, and after position 255 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame-start pulse from the sync detector |
| codec_ready | input | 1 | Codec-ready flag for the tag word |
| vra_en | input | 1 | Variable-rate mode; gates the sample-request flags |
| rd_pending | input | 1 | A read response is owed in this frame |
| rd_index | input | 7 | Register index to echo in slot 1 |
| rd_data | input | 16 | Register data to return in slot 2 |
| cap_valid | input | NUM_CAP | Bit i marks capture slot i+3 as valid |
| cap_data | input | NUM_CAP*CAP_W | Sample i in bits [18i+17:18i] |
| slot_req | input | NUM_CAP | Bit i is the sample-request flag of slot i+3 |
| gp_valid | input | 1 | Slot-12 status word is valid |
| gp_status | input | 20 | Status word for slot 12 |
| sdata | output | 1 | Serial frame output |

## Verification
The assertions assume that `frame_start` arrives as a single-cycle pulse. They also assume that `codec_ready` sampled on that edge governs the frame that follows, so the checker keeps its own copy of that flag and its own count of the current position. The stimulus drives every input on the falling edge. It holds `frame_start` high for exactly one cycle, and it changes inputs in the middle of a frame only to show that such changes are ignored. Because of this, the position counter in the checker always matches the frame being shifted out.

// File: rtl/ulf_pkg.sv
package ulf_pkg;
    localparam int TAG_BITS       = 16;
    localparam int SLOT_BITS      = 20;
    localparam int DATA_SLOTS     = 12;
    localparam int FIRST_CAP_SLOT = 3;
    localparam int MAX_CAP        = 9;
    localparam int IDX_BITS       = 7;
    localparam int RDAT_BITS      = 16;
    localparam int FRAME_BITS     = TAG_BITS + SLOT_BITS * DATA_SLOTS;

    typedef struct packed {
        logic                 pending;
        logic [IDX_BITS-1:0]  index;
        logic [RDAT_BITS-1:0] data;
    } rd_resp_t;

    typedef logic [SLOT_BITS-1:0] slot_word_t;
endpackage

// File: rtl/ulf_cap_slot.sv
module ulf_cap_slot
    import ulf_pkg::*;
#(
    parameter int CAP_W = 18
) (
    input  logic             valid,
    input  logic [CAP_W-1:0] sample,
    output slot_word_t       word
);
    localparam int PAD_W = SLOT_BITS - CAP_W;

    always_comb begin
        word = '0;
        if (valid) word = {sample, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/ulf_frame_build.sv
module ulf_frame_build
    import ulf_pkg::*;
#(
    parameter int NUM_CAP = 9,
    parameter int CAP_W   = 18
) (
    input  logic                     codec_ready,
    input  logic                     vra_en,
    input  rd_resp_t                 rd,
    input  logic [NUM_CAP-1:0]       cap_valid,
    input  logic [NUM_CAP*CAP_W-1:0] cap_data,
    input  logic [NUM_CAP-1:0]       slot_req,
    input  logic                     gp_valid,
    input  logic [SLOT_BITS-1:0]     gp_status,
    output logic [FRAME_BITS-1:0]    frame_vec
);
    localparam int IDX_LSB = SLOT_BITS - 1 - IDX_BITS;
    localparam int RD_LSB  = SLOT_BITS - RDAT_BITS;

    slot_word_t                   cap_word [NUM_CAP];
    logic [TAG_BITS-1:0]          tag;
    slot_word_t                   s1_word;
    slot_word_t                   s2_word;
    logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] slots_p;
    logic [FRAME_BITS-1:0]        raw;

    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
        ulf_cap_slot #(.CAP_W(CAP_W)) u_slot (
            .valid  (cap_valid[i]),
            .sample (cap_data[i*CAP_W +: CAP_W]),
            .word   (cap_word[i])
        );
    end

    always_comb begin
        tag = '0;
        tag[TAG_BITS-1] = 1'b1;
        tag[TAG_BITS-2] = rd.pending;
        tag[TAG_BITS-3] = rd.pending;
        for (int i = 0; i < NUM_CAP; i++)
            tag[TAG_BITS-1-(FIRST_CAP_SLOT+i)] = cap_valid[i];
        tag[TAG_BITS-1-DATA_SLOTS] = gp_valid;
    end

    always_comb begin
        s1_word = '0;
        if (rd.pending) s1_word[IDX_LSB +: IDX_BITS] = rd.index;
        for (int i = 0; i < NUM_CAP; i++)
            s1_word[SLOT_BITS-6-(FIRST_CAP_SLOT+i)] = vra_en & slot_req[i];
    end

    always_comb begin
        s2_word = '0;
        if (rd.pending) s2_word[RD_LSB +: RDAT_BITS] = rd.data;
    end

    always_comb begin
        slots_p = '0;
        slots_p[0] = s1_word;
        slots_p[1] = s2_word;
        for (int i = 0; i < NUM_CAP; i++)
            slots_p[FIRST_CAP_SLOT-1+i] = cap_word[i];
        slots_p[DATA_SLOTS-1] = gp_valid ? gp_status : '0;
    end

    always_comb begin
        raw = '0;
        raw[FRAME_BITS-1 -: TAG_BITS] = tag;
        for (int s = 0; s < DATA_SLOTS; s++)
            raw[FRAME_BITS-1-TAG_BITS-SLOT_BITS*s -: SLOT_BITS] = slots_p[s];
    end

    assign frame_vec = codec_ready ? raw : '0;
endmodule

// File: rtl/ulf_shift.sv
module ulf_shift #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         sout
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)       sreg <= '0;
        else if (load) sreg <= din;
        else           sreg <= {sreg[W-2:0], 1'b0};
    end

    assign sout = sreg[W-1];
endmodule

// File: rtl/upstream_frame_tx.sv
module upstream_frame_tx
    import ulf_pkg::*;
#(
    parameter int NUM_CAP = 9,
    parameter int CAP_W   = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic                     codec_ready,
    input  logic                     vra_en,
    input  logic                     rd_pending,
    input  logic [6:0]               rd_index,
    input  logic [15:0]              rd_data,
    input  logic [NUM_CAP-1:0]       cap_valid,
    input  logic [NUM_CAP*CAP_W-1:0] cap_data,
    input  logic [NUM_CAP-1:0]       slot_req,
    input  logic                     gp_valid,
    input  logic [19:0]              gp_status,
    output logic                     sdata
);
    rd_resp_t              rd;
    logic [FRAME_BITS-1:0] frame_vec;

    assign rd = '{pending: rd_pending, index: rd_index, data: rd_data};

    ulf_frame_build #(.NUM_CAP(NUM_CAP), .CAP_W(CAP_W)) u_build (
        .codec_ready (codec_ready),
        .vra_en      (vra_en),
        .rd          (rd),
        .cap_valid   (cap_valid),
        .cap_data    (cap_data),
        .slot_req    (slot_req),
        .gp_valid    (gp_valid),
        .gp_status   (gp_status),
        .frame_vec   (frame_vec)
    );

    ulf_shift #(.W(FRAME_BITS)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (frame_start),
        .din  (frame_vec),
        .sout (sdata)
    );
endmodule

// File: rtl/ulf_chk.sv
module ulf_chk
    import ulf_pkg::*;
#(
    parameter int NUM_CAP = 9,
    parameter int CAP_W   = 18
) (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic codec_ready,
    input logic sdata
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    logic [CW-1:0] pos;
    logic          ready_q;
    int            off;
    int            sl;
    logic          in_cap_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= CW'(FRAME_BITS);
            ready_q <= 1'b0;
        end else if (frame_start) begin
            pos     <= '0;
            ready_q <= codec_ready;
        end else if (int'(pos) != FRAME_BITS) begin
            pos <= pos + 1'b1;
        end
    end

    always_comb begin
        off = 0;
        sl  = 0;
        in_cap_pad = 1'b0;
        if (int'(pos) >= TAG_BITS && int'(pos) < FRAME_BITS) begin
            off = (int'(pos) - TAG_BITS) % SLOT_BITS;
            sl  = (int'(pos) - TAG_BITS) / SLOT_BITS + 1;
            in_cap_pad = (sl >= FIRST_CAP_SLOT) && (sl < FIRST_CAP_SLOT + NUM_CAP)
                         && (off >= CAP_W);
        end
    end

    // R2
    first_bit_ready_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (sdata == $past(codec_ready)));

    // R3
    not_ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && int'(pos) < FRAME_BITS) |-> !sdata);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(pos) == FRAME_BITS) |-> !sdata);

    // R7
    cap_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_cap_pad |-> !sdata);

    // R2
    tag_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(pos) >= TAG_BITS - 3 && int'(pos) < TAG_BITS) |-> !sdata);

    // R4
    slot1_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(pos) == TAG_BITS) |-> !sdata);
endmodule

bind upstream_frame_tx ulf_chk #(.NUM_CAP(NUM_CAP), .CAP_W(CAP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .codec_ready (codec_ready),
    .sdata       (sdata)
);

// File: tb/sim_upstream_frame_tx.sv
module sim_upstream_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 9;
    localparam int CW = 18;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            frame_start = 1'b0;
    logic            codec_ready = 1'b0;
    logic            vra_en = 1'b0;
    logic            rd_pending = 1'b0;
    logic [6:0]      rd_index = '0;
    logic [15:0]     rd_data = '0;
    logic [NC-1:0]   cap_valid = '0;
    logic [NC*CW-1:0] cap_data = '0;
    logic [NC-1:0]   slot_req = '0;
    logic            gp_valid = 1'b0;
    logic [19:0]     gp_status = '0;
    logic            sdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upstream_frame_tx #(.NUM_CAP(NC), .CAP_W(CW)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .codec_ready(codec_ready), .vra_en(vra_en),
        .rd_pending(rd_pending), .rd_index(rd_index), .rd_data(rd_data),
        .cap_valid(cap_valid), .cap_data(cap_data), .slot_req(slot_req),
        .gp_valid(gp_valid), .gp_status(gp_status), .sdata(sdata)
    );

    // Expected frame, indexed by send position (0 is sent first).
    function automatic logic [0:255] expect_frame();
        logic [0:255] e = '0;
        if (!codec_ready) return e;
        e[0] = 1'b1;
        e[1] = rd_pending;
        e[2] = rd_pending;
        for (int k = 3; k <= 11; k++) e[k] = cap_valid[k-3];
        e[12] = gp_valid;
        for (int j = 0; j < 7; j++) e[16+19-(12+j)] = rd_pending & rd_index[j];
        for (int k = 3; k <= 11; k++) e[21+k] = vra_en & slot_req[k-3];
        for (int j = 0; j < 16; j++) e[51-j] = rd_pending & rd_data[j];
        for (int k = 3; k <= 11; k++)
            for (int j = 0; j < CW; j++)
                e[16+20*(k-1)+17-j] = cap_valid[k-3] & cap_data[(k-3)*CW+j];
        for (int j = 0; j < 20; j++) e[236+19-j] = gp_valid & gp_status[j];
        return e;
    endfunction

    function automatic string req_of(int p);
        if (p < 16)  return "R2";
        if (p < 36)  return "R4";
        if (p < 56)  return "R6";
        if (p < 236) return "R7";
        return "R8";
    endfunction

    task automatic check_bit(logic exp_v, string req, int p);
        checks++;
        if (sdata !== exp_v) begin
            fails++;
            $display("FAIL %s pos %0d: sdata=%b expected=%b", req, p, sdata, exp_v);
        end
    endtask

    task automatic set_inputs(int seed, bit rdy, bit pend, bit vra, bit gp, logic [NC-1:0] vmask);
        codec_ready = rdy;
        rd_pending  = pend;
        vra_en      = vra;
        gp_valid    = gp;
        cap_valid   = vmask;
        rd_index    = 7'((seed * 13 + 5) & 7'h7f);
        rd_data     = 16'((seed * 40503 + 777) & 16'hffff);
        slot_req    = NC'((seed * 211 + 99) & 9'h1ff);
        gp_status   = 20'((seed * 92821 + 4321) & 20'hfffff);
        for (int i = 0; i < NC; i++)
            cap_data[i*CW +: CW] = CW'((seed * 7919 + i * 104729 + 3) & 18'h3ffff);
    endtask

    // Send a frame and compare every bit; label overrides the per-position tag.
    task automatic run_frame(string label, bit scramble);
        logic [0:255] e;
        e = expect_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int n = 0; n < 256; n++) begin
            check_bit(e[n], (label != "") ? label : req_of(n), n);
            if (scramble && n == 40) begin
                codec_ready = ~codec_ready; rd_pending = ~rd_pending;
                vra_en = ~vra_en; gp_valid = ~gp_valid;
                cap_valid = ~cap_valid; cap_data = ~cap_data;
                rd_data = ~rd_data; gp_status = ~gp_status; slot_req = ~slot_req;
            end
            @(negedge clk);
        end
        // R10: line idles low after the last bit
        for (int n = 0; n < 4; n++) begin
            check_bit(1'b0, "R10", 256 + n);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [0:255] ea;
        logic [0:255] eb;
        repeat (3) @(negedge clk);
        // R10: quiet during and after reset
        check_bit(1'b0, "R10", -1);
        rst = 1'b0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            check_bit(1'b0, "R10", -1);
        end

        // Sweep over the flag combinations with varied valid masks
        for (int cfg = 0; cfg < 16; cfg++) begin
            set_inputs(cfg + 1, 1'b1, cfg[0], cfg[1], cfg[2],
                       NC'((cfg * 109 + (cfg[3] ? 9'h1ff : 0)) & 9'h1ff));
            run_frame(cfg[1] ? "" : "R5", 1'b0);
        end

        // Walking single capture slot
        for (int k = 0; k < NC; k++) begin
            set_inputs(50 + k, 1'b1, 1'b1, 1'b1, 1'b1, NC'(1 << k));
            run_frame("R7", 1'b0);
        end

        // R3: codec not ready, everything else asserted
        set_inputs(77, 1'b0, 1'b1, 1'b1, 1'b1, '1);
        run_frame("R3", 1'b0);

        // R9: inputs change mid-frame
        set_inputs(88, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0a5);
        run_frame("R9", 1'b1);

        // R1: restart in the middle of a frame
        set_inputs(91, 1'b1, 1'b0, 1'b1, 1'b1, 9'h155);
        ea = expect_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int n = 0; n < 50; n++) begin
            check_bit(ea[n], "R1", n);
            @(negedge clk);
        end
        set_inputs(92, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0ff);
        eb = expect_frame();
        frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int n = 0; n < 256; n++) begin
            check_bit(eb[n], "R1", n);
            @(negedge clk);
        end
        check_bit(1'b0, "R10", 256);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule